// File: doc/BRIEF.md
# Serial Identifier CRC-8 Checker

This block checks an eight-byte device identifier as it streams in from a serial transport. Bytes arrive one per cycle on which the valid strobe is high, in the order the device sends them. The first seven bytes feed a CRC-8 register. The eighth byte is not added to the CRC. It is compared with the CRC result, and a one-cycle done pulse reports whether the two are equal.

The bytes received so far are also collected into a field register. Once seven bytes have arrived, its upper sixteen bits hold the customer field and the lower forty bits hold the unique number. A start strobe clears the block so the next frame can begin. Bytes beyond the eighth are ignored until that strobe.

The CRC datapath is chosen by a parameter. One option computes the update with a bit-serial XOR chain; the other looks it up in a 256-entry table built at elaboration. Both give the same result.

Top module: `sn_crc_check`

## Requirements
- R1: While rst_n is low, and on the first cycle after it rises, crc_o, match_o, done_o, cust_id_o and uniq_o are all zero.
- R2: The CRC uses generator 0x07 (x^8+x^2+x+1) and starts at 0x00. For each covered byte, the register is XORed with the byte and then shifted left eight times, MSB first; on each shift a carried-out 1 XORs 0x07 into the result. crc_o shows the new value on the cycle after the byte is accepted.
- R3: Only the first seven accepted bytes of a frame enter the CRC. crc_o does not change when the eighth byte is accepted.
- R4: On the cycle after the eighth byte is accepted, match_o is 1 exactly when that byte equals the CRC of the first seven. It holds that value until the next start.
- R5: done_o is high for exactly one cycle, the cycle after the eighth byte of a frame is accepted, and at no other time.
- R6: The field register is the concatenation of the accepted covered bytes, right-aligned, with the earliest byte most significant. After seven bytes, cust_id_o is the first byte (bits 15:8) and the second byte (bits 7:0). uniq_o holds bytes three to seven, with the third byte in bits 39:32.
- R7: Bytes strobed after the eighth are ignored until the next start: crc_o, match_o, cust_id_o and uniq_o keep their values and done_o stays low.
- R8: start_i clears the byte count, the CRC, match_o and both fields on the next cycle. When start_i and byte_vld_i are high in the same cycle, the byte is dropped.
- R9: A cycle with byte_vld_i low changes nothing, so gaps between bytes give the same result as back-to-back bytes.
- R10: The bit-serial datapath (USE_TABLE=0) and the table datapath (USE_TABLE=1) give identical outputs on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Clears the frame state |
| byte_vld_i | input | 1 | byte_i holds a received byte |
| byte_i | input | 8 | Received byte |
| crc_o | output | 8 | Running CRC register |
| match_o | output | 1 | Reference byte equals computed CRC |
| done_o | output | 1 | One-cycle pulse after the eighth byte |
| cust_id_o | output | 16 | Customer field |
| uniq_o | output | 40 | Unique number field |

## Verification
The assertions check five properties on every cycle:
- done_o is a single-cycle pulse that follows the eighth byte.
- match_o rises only together with done_o.
- crc_o stays frozen once seven bytes have been taken.
- The state clears one cycle after a start.
- Idle cycles change nothing.

The arithmetic itself can only be shown by the bench scenarios. A per-cycle model compares both datapath variants against it. This covers the CRC values, the match result for correct and corrupted reference bytes, field placement, surplus bytes, a start arriving mid-frame or together with a strobe, and gaps between bytes.

// File: rtl/sncrc_pkg.sv
package sncrc_pkg;
   localparam int SNC_BYTE_W = 8;
   typedef logic [SNC_BYTE_W-1:0] snc_byte_t;

   // one byte through the MSB-first division by the generator
   function automatic snc_byte_t snc_crc_step(snc_byte_t crc, snc_byte_t data, snc_byte_t poly);
      snc_byte_t r;
      r = crc ^ data;
      for (int i = 0; i < SNC_BYTE_W; i++) begin
         r = r[SNC_BYTE_W-1] ? ({r[SNC_BYTE_W-2:0], 1'b0} ^ poly) : {r[SNC_BYTE_W-2:0], 1'b0};
      end
      return r;
   endfunction
endpackage

// File: rtl/sncrc_seq.sv
module sncrc_seq #(
   parameter int NUM_BYTES = 8,
   localparam int CNT_W = $clog2(NUM_BYTES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             vld_i,
   output logic [CNT_W-1:0] count_o,
   output logic             cover_en_o,
   output logic             last_o
);
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NUM_BYTES - 1);
   localparam logic [CNT_W-1:0] FULL     = CNT_W'(NUM_BYTES);

   logic [CNT_W-1:0] cnt_q;
   logic             take;

   assign take       = vld_i && !start_i && (cnt_q != FULL);
   assign cover_en_o = take && (cnt_q < LAST_IDX);
   assign last_o     = take && (cnt_q == LAST_IDX);
   assign count_o    = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (start_i) cnt_q <= '0;
      else if (take)    cnt_q <= cnt_q + CNT_W'(1);
   end
endmodule

// File: rtl/sncrc_engine.sv
module sncrc_engine
   import sncrc_pkg::*;
#(
   parameter snc_byte_t POLY      = 8'h07,
   parameter snc_byte_t INIT      = 8'h00,
   parameter bit        USE_TABLE = 1'b0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      clear_i,
   input  logic      en_i,
   input  snc_byte_t byte_i,
   output snc_byte_t crc_o
);
   localparam int TBL_N = 1 << SNC_BYTE_W;

   snc_byte_t crc_q;
   snc_byte_t crc_nxt;

   generate
      if (USE_TABLE) begin : g_table
         snc_byte_t tbl [TBL_N];
         for (genvar g = 0; g < TBL_N; g++) begin : g_ent
            assign tbl[g] = snc_crc_step('0, snc_byte_t'(g), POLY);
         end
         assign crc_nxt = tbl[crc_q ^ byte_i];
      end else begin : g_bitwise
         assign crc_nxt = snc_crc_step(crc_q, byte_i, POLY);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       crc_q <= INIT;
      else if (clear_i) crc_q <= INIT;
      else if (en_i)    crc_q <= crc_nxt;
   end

   assign crc_o = crc_q;
endmodule

// File: rtl/sncrc_fields.sv
module sncrc_fields
   import sncrc_pkg::*;
#(
   parameter int NUM_BYTES  = 8,
   parameter int CUST_BYTES = 2,
   localparam int COV_W  = (NUM_BYTES - 1) * SNC_BYTE_W,
   localparam int CUST_W = CUST_BYTES * SNC_BYTE_W,
   localparam int UNIQ_W = COV_W - CUST_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              en_i,
   input  snc_byte_t         byte_i,
   output logic [CUST_W-1:0] cust_o,
   output logic [UNIQ_W-1:0] uniq_o
);
   logic [COV_W-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sh_q <= '0;
      else if (clear_i) sh_q <= '0;
      else if (en_i)    sh_q <= {sh_q[COV_W-SNC_BYTE_W-1:0], byte_i};
   end

   assign cust_o = sh_q[COV_W-1:UNIQ_W];
   assign uniq_o = sh_q[UNIQ_W-1:0];
endmodule

// File: rtl/sn_crc_check.sv
module sn_crc_check
   import sncrc_pkg::*;
#(
   parameter int        NUM_BYTES  = 8,
   parameter int        CUST_BYTES = 2,
   parameter snc_byte_t POLY       = 8'h07,
   parameter snc_byte_t INIT       = 8'h00,
   parameter bit        USE_TABLE  = 1'b0
) (
   input  logic                                      clk,
   input  logic                                      rst_n,
   input  logic                                      start_i,
   input  logic                                      byte_vld_i,
   input  logic [7:0]                                byte_i,
   output logic [7:0]                                crc_o,
   output logic                                      match_o,
   output logic                                      done_o,
   output logic [CUST_BYTES*8-1:0]                   cust_id_o,
   output logic [(NUM_BYTES-1-CUST_BYTES)*8-1:0]     uniq_o
);
   localparam int CNT_W = $clog2(NUM_BYTES + 1);

   generate
      if (NUM_BYTES < 3) begin : g_bad_frame
         $error("sn_crc_check: NUM_BYTES must be at least 3");
      end
      if (CUST_BYTES < 1 || CUST_BYTES > NUM_BYTES - 2) begin : g_bad_cust
         $error("sn_crc_check: CUST_BYTES must leave room for a unique field");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic             cover_en;
   logic             last_byte;
   snc_byte_t        crc_w;
   logic             match_q;
   logic             done_q;

   sncrc_seq #(.NUM_BYTES(NUM_BYTES)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .vld_i      (byte_vld_i),
      .count_o    (cnt_q),
      .cover_en_o (cover_en),
      .last_o     (last_byte)
   );

   sncrc_engine #(.POLY(POLY), .INIT(INIT), .USE_TABLE(USE_TABLE)) u_eng (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (start_i),
      .en_i    (cover_en),
      .byte_i  (byte_i),
      .crc_o   (crc_w)
   );

   sncrc_fields #(.NUM_BYTES(NUM_BYTES), .CUST_BYTES(CUST_BYTES)) u_fld (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (start_i),
      .en_i    (cover_en),
      .byte_i  (byte_i),
      .cust_o  (cust_id_o),
      .uniq_o  (uniq_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         match_q <= 1'b0;
         done_q  <= 1'b0;
      end else if (start_i) begin
         match_q <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= last_byte;
         if (last_byte) match_q <= (byte_i == crc_w);
      end
   end

   assign crc_o   = crc_w;
   assign match_o = match_q;
   assign done_o  = done_q;
endmodule

// File: rtl/sncrc_check_sva.sv
module sncrc_check_sva #(
   parameter int          NUM_BYTES  = 8,
   parameter int          CUST_BYTES = 2,
   parameter logic [7:0]  INIT       = 8'h00,
   localparam int CNT_W  = $clog2(NUM_BYTES + 1),
   localparam int CUST_W = CUST_BYTES * 8,
   localparam int UNIQ_W = (NUM_BYTES - 1 - CUST_BYTES) * 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              byte_vld_i,
   input logic [7:0]        crc_o,
   input logic              match_o,
   input logic              done_o,
   input logic [CUST_W-1:0] cust_id_o,
   input logic [UNIQ_W-1:0] uniq_o,
   input logic [CNT_W-1:0]  cnt
);
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NUM_BYTES - 1);
   localparam logic [CNT_W-1:0] FULL     = CNT_W'(NUM_BYTES);

   p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_done_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> ($past(byte_vld_i) && !$past(start_i) && $past(cnt) == LAST_IDX));

   p_match_with_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(match_o) |-> done_o);

   p_crc_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt >= LAST_IDX && !start_i) |=> $stable(crc_o));

   p_surplus_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == FULL && !start_i) |=>
         ($stable(crc_o) && $stable(match_o) && !done_o && $stable(cust_id_o) && $stable(uniq_o)));

   p_start_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (cnt == '0 && crc_o == INIT && !match_o && !done_o && cust_id_o == '0 && uniq_o == '0));

   p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!byte_vld_i && !start_i) |=> ($stable(crc_o) && $stable(cnt) && $stable(uniq_o) && !done_o));
endmodule

bind sn_crc_check sncrc_check_sva #(
   .NUM_BYTES  (NUM_BYTES),
   .CUST_BYTES (CUST_BYTES),
   .INIT       (INIT)
) u_sva (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .byte_vld_i (byte_vld_i),
   .crc_o      (crc_o),
   .match_o    (match_o),
   .done_o     (done_o),
   .cust_id_o  (cust_id_o),
   .uniq_o     (uniq_o),
   .cnt        (cnt_q)
);

// File: tb/test_sn_crc_check.sv
module test_sn_crc_check;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       vld = 1'b0;
   logic [7:0] din = 8'h00;

   logic [7:0]  crc_a, crc_b;
   logic        match_a, match_b, done_a, done_b;
   logic [15:0] cust_a, cust_b;
   logic [39:0] uniq_a, uniq_b;

   always #4 clk = ~clk;

   sn_crc_check #(.USE_TABLE(1'b0)) i_sn_crc_check (
      .clk(clk), .rst_n(rst_n), .start_i(start), .byte_vld_i(vld), .byte_i(din),
      .crc_o(crc_a), .match_o(match_a), .done_o(done_a), .cust_id_o(cust_a), .uniq_o(uniq_a));

   sn_crc_check #(.USE_TABLE(1'b1)) i_sn_crc_check_tbl (
      .clk(clk), .rst_n(rst_n), .start_i(start), .byte_vld_i(vld), .byte_i(din),
      .crc_o(crc_b), .match_o(match_b), .done_o(done_b), .cust_id_o(cust_b), .uniq_o(uniq_b));

   int n_chk  = 0;
   int n_fail = 0;
   int done_seen = 0;

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // bit-serial long division of the message stream, MSB first
   function automatic logic [7:0] ref_crc(logic [7:0] q[$], int n);
      logic [7:0] c = 8'h00;
      for (int k = 0; k < n; k++) begin
         for (int b = 7; b >= 0; b--) begin
            logic fb;
            fb = c[7] ^ q[k][b];
            c  = {c[6:0], 1'b0};
            if (fb) c = c ^ 8'h07;
         end
      end
      return c;
   endfunction

   // behavioural reference model
   logic [7:0] mq[$];
   logic       m_done  = 1'b0;
   logic       m_match = 1'b0;

   always @(posedge clk) begin
      if (!rst_n || start) begin
         mq.delete();
         m_done  = 1'b0;
         m_match = 1'b0;
      end else if (vld && mq.size() < 8) begin
         mq.push_back(din);
         if (mq.size() == 8) begin
            m_done  = 1'b1;
            m_match = (din == ref_crc(mq, 7));
         end else begin
            m_done = 1'b0;
         end
      end else begin
         m_done = 1'b0;
      end
   end

   always @(negedge clk) begin
      int         n;
      logic [55:0] v;
      n = (mq.size() < 7) ? mq.size() : 7;
      v = '0;
      for (int k = 0; k < n; k++) v = {v[47:0], mq[k]};
      if (!rst_n) begin
         chk("R1 crc", 64'(crc_a), 64'h0);
         chk("R1 flags", 64'({match_a, done_a}), 64'h0);
         chk("R1 fields", 64'({cust_a, uniq_a}), 64'h0);
      end else begin
         chk("R2 crc", 64'(crc_a), 64'(ref_crc(mq, n)));
         chk("R4 match", 64'(match_a), 64'(m_match));
         chk("R5 done", 64'(done_a), 64'(m_done));
         chk("R6 cust", 64'(cust_a), 64'(v[55:40]));
         chk("R6 uniq", 64'(uniq_a), 64'(v[39:0]));
         chk("R10 variants", 64'({crc_b, match_b, done_b}), 64'({crc_a, match_a, done_a}));
         chk("R10 fields", 64'({cust_b, uniq_b}), 64'({cust_a, uniq_a}));
      end
      if (done_a) done_seen++;
   end

   task automatic idle(int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         start = 1'b0;
         vld   = 1'b0;
      end
   endtask

   task automatic send(logic [7:0] b);
      @(negedge clk);
      start = 1'b0;
      vld   = 1'b1;
      din   = b;
   endtask

   task automatic do_start(logic with_byte, logic [7:0] b);
      @(negedge clk);
      start = 1'b1;
      vld   = with_byte;
      din   = b;
   endtask

   task automatic send_frame(logic [7:0] f[8], int gap);
      for (int k = 0; k < 8; k++) begin
         send(f[k]);
         if (gap > 0) idle(gap);
      end
      idle(1);
   endtask

   function automatic void make_frame(ref logic [7:0] f[8], input logic [7:0] b[7], input logic bad);
      logic [7:0] q[$];
      for (int k = 0; k < 7; k++) begin
         f[k] = b[k];
         q.push_back(b[k]);
      end
      f[7] = ref_crc(q, 7) ^ (bad ? 8'h01 : 8'h00);
   endfunction

   logic [7:0] fa[8], fb[8], ff[8];
   int d0;

   initial begin
      make_frame(fa, '{8'h00, 8'h00, 8'h12, 8'h34, 8'h56, 8'h78, 8'h9A}, 1'b0);
      make_frame(fb, '{8'hAB, 8'hCD, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05}, 1'b1);
      make_frame(ff, '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF}, 1'b0);
      idle(3);
      chk("R1 reset crc", 64'(crc_a), 64'h0);
      rst_n = 1'b1;
      idle(1);
      chk("R1 after release", 64'({match_a, done_a, cust_a}), 64'h0);

      // valid frame, no customer field
      d0 = done_seen;
      send_frame(fa, 0);
      idle(1);
      chk("R4 good frame match", 64'(match_a), 64'h1);
      chk("R5 one done", 64'(done_seen - d0), 64'h1);
      chk("R6 cust zero", 64'(cust_a), 64'h0);
      chk("R6 uniq", 64'(uniq_a), 64'h123456789A);
      chk("R3 crc is reference", 64'(crc_a), 64'(fa[7]));

      // corrupted reference byte, nonzero customer field
      do_start(1'b0, 8'h00);
      d0 = done_seen;
      send_frame(fb, 0);
      idle(1);
      chk("R4 bad frame no match", 64'(match_a), 64'h0);
      chk("R6 cust field", 64'(cust_a), 64'hABCD);
      chk("R6 uniq field", 64'(uniq_a), 64'h0102030405);
      chk("R5 one done", 64'(done_seen - d0), 64'h1);

      // gaps between bytes
      do_start(1'b0, 8'h00);
      send_frame(fa, 2);
      idle(1);
      chk("R9 gapped match", 64'(match_a), 64'h1);

      // surplus bytes after the eighth
      do_start(1'b0, 8'h00);
      d0 = done_seen;
      send_frame(fa, 0);
      send(8'h55); send(8'hAA); send(fa[7] ^ 8'hFF);
      idle(2);
      chk("R7 no second done", 64'(done_seen - d0), 64'h1);
      chk("R7 match kept", 64'(match_a), 64'h1);
      chk("R7 crc kept", 64'(crc_a), 64'(fa[7]));
      chk("R7 uniq kept", 64'(uniq_a), 64'h123456789A);

      // start mid-frame, then start coinciding with a strobe
      do_start(1'b0, 8'h00);
      send(8'h11); send(8'h22); send(8'h33); send(8'h44);
      do_start(1'b1, 8'h77);
      idle(1);
      chk("R8 cleared crc", 64'(crc_a), 64'h0);
      chk("R8 cleared fields", 64'({cust_a, uniq_a}), 64'h0);
      make_frame(fb, '{8'hAB, 8'hCD, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05}, 1'b0);
      d0 = done_seen;
      send_frame(fb, 0);
      idle(1);
      chk("R8 fresh frame match", 64'(match_a), 64'h1);
      chk("R8 one done", 64'(done_seen - d0), 64'h1);

      // all-ones frame
      do_start(1'b0, 8'h00);
      send_frame(ff, 1);
      idle(1);
      chk("R2 all-ones crc", 64'(crc_a), 64'(ff[7]));
      chk("R10 table matches", 64'(crc_b), 64'(ff[7]));
      chk("R4 all-ones match", 64'(match_a), 64'h1);

      idle(2);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(8 * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule